// File: doc/BRIEF.md
# Range-Checked PWM Generator with Period Restart

This block drives a single pulse-width-modulated output. Software-facing logic upstream supplies a frequency code in tenths of a hertz and a duty cycle in whole percent. The block turns the pair into a period length and a high time in system clock cycles, using a sequential divider that runs once per settings change. Each period starts with the output high for the high time and ends with it low for the rest.

Every frequency and duty pair is checked against a band table in which the allowed duty window gets narrower as the frequency rises. A pair outside the table holds the output low and raises a high-limit or low-limit flag in an 8-bit status word. The validity flag in that word shows that the settings are in range and the generator is running.

An enable command and a gate input must both be high for the period generator to run. A synchronization input restarts the current period from zero. Synchronization requests that arrive too soon after the last accepted one are ignored. New settings are taken only at a period boundary, on an accepted restart, or when the generator starts, so a running period is never cut short.

Top module: `pwm_gen_top`

## Requirements
- R1: The period is CLK_HZ*10/freq_code cycles, rounded down. The high time is period*duty_pct/100, rounded down, with a minimum of 1 cycle. The output is high during the first high-time cycles of each period and low for the rest.
- R2: While run_en is 0, pwm_out is 0 in the same cycle and the period generator is cleared.
- R3: While gate_in is 0, the generator is stopped and cleared and pwm_out is 0. When gate_in returns to 1, the next period starts from its first cycle, with the output high.
- R4: An accepted sync_in while the generator runs sets the cycle count to zero. It also loads the latest computed settings, so the output is high in the following cycle.
- R5: After an accepted sync_in, further sync_in requests are ignored for CLK_HZ/200 cycles (5 ms). A request exactly CLK_HZ/200 cycles after the accepted one is accepted.
- R6: A pair is in range when freq_code is between 1 and 40000 and duty_pct lies inside the band for that code: codes up to 2500 allow 5..95; up to 5000 allow 10..90; up to 10000 allow 20..80; up to 15000 allow 30..70; up to 20000 allow 40..60; up to 40000 allow only 50.
- R7: A freq_code of 0 sets the low-limit flag (status bit 5). A freq_code above 40000 sets the high-limit flag (status bit 4).
- R8: For a frequency that is in range, a duty below the band minimum sets status bit 5, and a duty above the band maximum sets status bit 4.
- R9: While either limit flag is set, pwm_out is 0 and the validity flag is 0.
- R10: Status bit 3 (validity) is a register. It is 1 one cycle after a cycle in which run_en is 1, the pair is in range and the generator has started. Status bits 4 and 5 are registered from the current pair with a latency of one cycle. Status bits 0-2, 6 and 7 are always 0.
- R11: A settings change during a period does not shorten that period. It takes effect no earlier than the next period boundary or accepted sync_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Enable command for the output |
| gate_in | input | 1 | Lets the period generator run while high |
| sync_in | input | 1 | Restart request for the current period |
| freq_code | input | FREQ_W | Output frequency in 0.1 Hz units |
| duty_pct | input | DUTY_W | High time in whole percent |
| pwm_out | output | 1 | Modulated output |
| status | output | 8 | Bit 5 low limit, bit 4 high limit, bit 3 valid, other bits 0 |

## Verification
The bench builds the block with CLK_HZ set to 40000. With that value the fastest legal frequency gives a 10-cycle period, and the 5 ms restart lockout shrinks to 200 cycles. Whole periods at 1, 3 and 4 kHz, the exact edge of the lockout window, and the case where a mid-period change leaves the current period unchanged all fit in a few hundred cycles. All band edges, including 0.1 Hz with its 400000-cycle period, can be checked for status without running a full period.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
// Shared types and the duty band table of the PWM generator.
// Assumes frequency codes in 0.1 Hz units and duty in whole percent.
package pwm_pkg;

    localparam int unsigned FREQ_CODE_MAX = 40000;
    localparam int unsigned PCT_SCALE     = 100;

    typedef struct packed {
        logic [6:0] lo;
        logic [6:0] hi;
    } duty_window_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PER,
        PH_HIGH
    } div_phase_t;

    // Returns the allowed duty window for an in-range frequency code.
    function automatic duty_window_t window_for(input int unsigned code);
        duty_window_t w;
        if (code <= 2500)       w = '{lo: 7'd5,  hi: 7'd95};
        else if (code <= 5000)  w = '{lo: 7'd10, hi: 7'd90};
        else if (code <= 10000) w = '{lo: 7'd20, hi: 7'd80};
        else if (code <= 15000) w = '{lo: 7'd30, hi: 7'd70};
        else if (code <= 20000) w = '{lo: 7'd40, hi: 7'd60};
        else                    w = '{lo: 7'd50, hi: 7'd50};
        return w;
    endfunction

endpackage

// File: rtl/pwm_band_check.sv
`timescale 1ns/1ps
// Combinational range check of a frequency/duty pair against the band table.
// Assumes: at most one of the two flags is raised; frequency faults win over duty faults.
module pwm_band_check
    import pwm_pkg::*;
#(
    parameter int FREQ_W = 16,
    parameter int DUTY_W = 7
) (
    input  logic [FREQ_W-1:0] freq_code,
    input  logic [DUTY_W-1:0] duty_pct,
    output logic              over_lim,
    output logic              under_lim
);

    duty_window_t win;

    // Classify the pair as above, below or inside its band.
    always_comb begin
        win       = window_for(32'(freq_code));
        over_lim  = 1'b0;
        under_lim = 1'b0;
        if (freq_code == '0)
            under_lim = 1'b1;
        else if (32'(freq_code) > FREQ_CODE_MAX)
            over_lim = 1'b1;
        else if (32'(duty_pct) < 32'(win.lo))
            under_lim = 1'b1;
        else if (32'(duty_pct) > 32'(win.hi))
            over_lim = 1'b1;
    end

endmodule

// File: rtl/pwm_seq_div.sv
`timescale 1ns/1ps
// Restoring unsigned divider, one quotient bit per cycle, W cycles per result.
// Assumes den is non-zero; a new start abandons any division in progress.
module pwm_seq_div #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);

    localparam int SW = $clog2(W + 1);
    localparam int PW = 2 * W + 1;

    logic [W:0]    rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  den_q;
    logic [W-1:0]  num_q;
    logic [SW-1:0] step_q;
    logic          busy_q;
    logic          done_q;
    logic [W:0]    shifted;
    logic          fits;
    logic [W:0]    rem_nx;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        shifted = {rem_q[W-1:0], quo_q[W-1]};
        fits    = shifted >= {1'b0, den_q};
        rem_nx  = fits ? shifted - {1'b0, den_q} : shifted;
    end

    // Iterate the division and flag completion for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            num_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                quo_q  <= num;
                den_q  <= den;
                num_q  <= num;
                step_q <= SW'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q  <= rem_nx;
                quo_q  <= {quo_q[W-2:0], fits};
                step_q <= step_q - 1'b1;
                if (step_q == SW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quo  = quo_q;

    // R1: a finished division reconstructs its operands exactly.
    p_div_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (PW'(quo_q) * PW'(den_q) + PW'(rem_q) == PW'(num_q)) && (rem_q < {1'b0, den_q}));

endmodule

// File: rtl/pwm_sync_gate.sv
`timescale 1ns/1ps
// Accepts a restart request only when the lockout window since the last accepted one has run out.
// Assumes GAP_CYC >= 2.
module pwm_sync_gate #(
    parameter int GAP_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic sync_acc
);

    localparam int GW = $clog2(GAP_CYC + 1);

    logic [GW-1:0] gap_q;

    assign sync_acc = sync_in && (gap_q == '0);

    // Count down the lockout that follows each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (sync_acc)
            gap_q <= GW'(GAP_CYC - 1);
        else if (gap_q != '0)
            gap_q <= gap_q - 1'b1;
    end

    // R5: two accepted requests never occur back to back.
    p_single_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_acc |=> !sync_acc);

endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
// Period counter and comparator; loads new period/high time at start, boundary or restart.
// Assumes ld_per >= 1 whenever ld_ok is high.
module pwm_timebase #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sync_acc,
    input  logic             ld_ok,
    input  logic [CNT_W-1:0] ld_per,
    input  logic [CNT_W-1:0] ld_high,
    output logic             pwm_out,
    output logic             started
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] high_q;
    logic             started_q;
    logic             wrap;

    assign wrap = (cnt_q == per_q - 1'b1);

    // Advance, wrap or restart the period count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            per_q     <= '0;
            high_q    <= '0;
            started_q <= 1'b0;
        end else if (!run) begin
            cnt_q     <= '0;
            started_q <= 1'b0;
        end else if (!started_q) begin
            if (ld_ok) begin
                cnt_q     <= '0;
                per_q     <= ld_per;
                high_q    <= ld_high;
                started_q <= 1'b1;
            end
        end else if (sync_acc || wrap) begin
            cnt_q <= '0;
            if (ld_ok) begin
                per_q  <= ld_per;
                high_q <= ld_high;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign pwm_out = run && started_q && (cnt_q < high_q);
    assign started = started_q;

    // R1: the count stays inside the loaded period.
    p_cnt_in_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (cnt_q < per_q));

    // R3: a stopped generator is cleared on the next edge.
    p_stop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0) && !started_q);

    // R4: an accepted restart zeroes the count.
    p_sync_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && started_q && sync_acc) |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_gen_top.sv
`timescale 1ns/1ps
// PWM generator: range check, period/high-time computation, restart lockout and output.
// Assumes CLK_HZ >= 8000 so every legal frequency gives a period of at least 2 cycles.
module pwm_gen_top
    import pwm_pkg::*;
#(
    parameter int CLK_HZ = 50000000,
    parameter int FREQ_W = 16,
    parameter int DUTY_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              gate_in,
    input  logic              sync_in,
    input  logic [FREQ_W-1:0] freq_code,
    input  logic [DUTY_W-1:0] duty_pct,
    output logic              pwm_out,
    output logic [7:0]        status
);

    localparam longint unsigned PER_NUM = 64'(CLK_HZ) * 64'd10;
    localparam int CNT_W    = $clog2(PER_NUM + 1);
    localparam int DIV_W    = CNT_W + DUTY_W;
    localparam int SYNC_GAP = CLK_HZ / 200;

    logic              cmb_hi, cmb_lo, band_ok;
    logic              st_hi_q, st_lo_q, st_vld_q;
    logic              run, sync_acc, tb_started;
    logic              launch;
    logic [FREQ_W-1:0] set_f_q;
    logic [DUTY_W-1:0] set_d_q;
    div_phase_t        phase_q;
    logic [CNT_W-1:0]  per_tmp_q, pend_per_q, pend_high_q;
    logic              res_vld_q;
    logic              div_start, div_done;
    logic [DIV_W-1:0]  div_num, div_den, div_quo;

    pwm_band_check #(.FREQ_W(FREQ_W), .DUTY_W(DUTY_W)) i_band (
        .freq_code (freq_code),
        .duty_pct  (duty_pct),
        .over_lim  (cmb_hi),
        .under_lim (cmb_lo)
    );

    assign band_ok = !cmb_hi && !cmb_lo;
    assign run     = run_en && gate_in && !st_hi_q && !st_lo_q;

    // Start a new computation on changed in-range settings, or chain the second division.
    always_comb begin
        launch    = band_ok && ((freq_code != set_f_q) || (duty_pct != set_d_q));
        div_start = launch || ((phase_q == PH_PER) && div_done);
        if (launch) begin
            div_num = DIV_W'(PER_NUM);
            div_den = DIV_W'(freq_code);
        end else begin
            div_num = DIV_W'(div_quo[CNT_W-1:0]) * DIV_W'(set_d_q);
            div_den = DIV_W'(PCT_SCALE);
        end
    end

    pwm_seq_div #(.W(DIV_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    // Sequence the two divisions and publish the pending period and high time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_f_q     <= '0;
            set_d_q     <= '0;
            phase_q     <= PH_IDLE;
            per_tmp_q   <= '0;
            pend_per_q  <= '0;
            pend_high_q <= '0;
            res_vld_q   <= 1'b0;
        end else if (launch) begin
            set_f_q <= freq_code;
            set_d_q <= duty_pct;
            phase_q <= PH_PER;
        end else if (div_done) begin
            if (phase_q == PH_PER) begin
                per_tmp_q <= div_quo[CNT_W-1:0];
                phase_q   <= PH_HIGH;
            end else if (phase_q == PH_HIGH) begin
                pend_per_q  <= per_tmp_q;
                pend_high_q <= (div_quo == '0) ? CNT_W'(1) : div_quo[CNT_W-1:0];
                res_vld_q   <= 1'b1;
                phase_q     <= PH_IDLE;
            end
        end
    end

    pwm_sync_gate #(.GAP_CYC(SYNC_GAP)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .sync_acc (sync_acc)
    );

    pwm_timebase #(.CNT_W(CNT_W)) i_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sync_acc (sync_acc),
        .ld_ok    (res_vld_q),
        .ld_per   (pend_per_q),
        .ld_high  (pend_high_q),
        .pwm_out  (pwm_out),
        .started  (tb_started)
    );

    // Register the limit flags and the validity flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_hi_q  <= 1'b0;
            st_lo_q  <= 1'b0;
            st_vld_q <= 1'b0;
        end else begin
            st_hi_q  <= cmb_hi;
            st_lo_q  <= cmb_lo;
            st_vld_q <= run_en && band_ok && tb_started;
        end
    end

    assign status = {2'b00, st_lo_q, st_hi_q, st_vld_q, 3'b000};

    // R9: a raised limit flag keeps the output low.
    p_limit_mutes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_hi_q || st_lo_q) |-> !pwm_out);

    // R7: the two limit flags are never raised together.
    p_flags_one_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_hi_q && st_lo_q));

    // R10: validity follows an enabled cycle.
    p_valid_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_vld_q |-> $past(run_en));

endmodule

// File: tb/test_pwm_gen_top.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model compared on every clock, plus targeted checks.
module test_pwm_gen_top;

    localparam int CLK_HZ = 40000;
    localparam int GAP    = CLK_HZ / 200;
    localparam longint K  = longint'(CLK_HZ) * 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        gate_in = 1'b0;
    logic        sync_in = 1'b0;
    logic [15:0] freq_code = 16'd10000;
    logic [6:0]  duty_pct = 7'd25;
    logic        pwm_out;
    logic [7:0]  status;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    string cur_req = "R10";

    // model state
    bit     m_hi, m_lo, m_vld, m_started;
    longint m_cnt, m_per, m_high;
    int     m_gap;
    int     chg_age = 0;
    bit     unknown = 1;

    pwm_gen_top #(.CLK_HZ(CLK_HZ)) i_pwm_gen_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .gate_in   (gate_in),
        .sync_in   (sync_in),
        .freq_code (freq_code),
        .duty_pct  (duty_pct),
        .pwm_out   (pwm_out),
        .status    (status)
    );

    always #10 clk = ~clk;

    function automatic void exp_flags(input int f, input int d, output bit hi, output bit lo);
        int dmin, dmax;
        hi = 0; lo = 0;
        if (f == 0) begin lo = 1; return; end
        if (f > 40000) begin hi = 1; return; end
        case (1'b1)
            (f <= 2500):  begin dmin = 5;  dmax = 95; end
            (f <= 5000):  begin dmin = 10; dmax = 90; end
            (f <= 10000): begin dmin = 20; dmax = 80; end
            (f <= 15000): begin dmin = 30; dmax = 70; end
            (f <= 20000): begin dmin = 40; dmax = 60; end
            default:      begin dmin = 50; dmax = 50; end
        endcase
        if (d < dmin) lo = 1;
        else if (d > dmax) hi = 1;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model update on each edge, then compare a quarter period later.
    always @(posedge clk) begin
        bit c_hi, c_lo, run, acc;
        longint pp, ph;
        int gap_n;
        bit vld_n;
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_vld = 0; m_started = 0;
            m_cnt = 0; m_per = 0; m_high = 0; m_gap = 0; chg_age = 0;
        end else begin
            exp_flags(int'(freq_code), int'(duty_pct), c_hi, c_lo);
            run = run_en && gate_in && !m_hi && !m_lo;
            acc = sync_in && (m_gap == 0);
            gap_n = acc ? GAP - 1 : (m_gap > 0 ? m_gap - 1 : 0);
            vld_n = run_en && !c_hi && !c_lo && m_started;
            if (!c_hi && !c_lo) begin
                pp = K / longint'(freq_code);
                ph = pp * longint'(duty_pct) / 100;
                if (ph == 0) ph = 1;
            end else begin
                pp = 1; ph = 1;
            end
            if (unknown && chg_age >= 100 && (!m_started || (run && acc))) unknown = 0;
            if (!run) begin
                m_cnt = 0; m_started = 0;
            end else if (!m_started) begin
                m_cnt = 0; m_per = pp; m_high = ph; m_started = 1;
            end else if (acc || m_cnt == m_per - 1) begin
                m_cnt = 0; m_per = pp; m_high = ph;
            end else begin
                m_cnt++;
            end
            m_hi = c_hi; m_lo = c_lo; m_vld = vld_n; m_gap = gap_n;
            chg_age++;
        end
        #5;
        begin
            bit exp_pwm;
            logic [7:0] exp_st;
            exp_pwm = run_en && gate_in && !m_hi && !m_lo && m_started && (m_cnt < m_high);
            exp_st  = {2'b00, m_lo, m_hi, m_vld, 3'b000};
            n_checks++;
            if (status !== exp_st || (!unknown && pwm_out !== exp_pwm)) begin
                n_fail++;
                $display("FAIL %s: status %b pwm %b expected status %b pwm %b at %0t",
                         cur_req, status, pwm_out, exp_st, exp_pwm, $time);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_params(input int f, input int d);
        freq_code = 16'(f);
        duty_pct  = 7'(d);
        unknown   = 1;
        chg_age   = 0;
    endtask

    task automatic pulse_sync;
        sync_in = 1'b1;
        tick(1);
        sync_in = 1'b0;
    endtask

    task automatic count_high(input int n, output int hits);
        hits = 0;
        for (int j = 0; j < n; j++) begin
            if (pwm_out) hits++;
            tick(1);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int hits;
        tick(5);
        // R10: reset state
        chk("R10 reset pwm", longint'(pwm_out), 0);
        chk("R10 reset status", longint'(status), 0);
        rst_n = 1'b1;
        tick(120);

        // R1: 1 kHz, 25 % gives a 40-cycle period with 10 high cycles
        cur_req = "R1";
        run_en = 1'b1; gate_in = 1'b1;
        tick(250);
        pulse_sync;
        count_high(40, hits);
        chk("R1 high cycles one period", hits, (K / 10000) * 25 / 100);
        count_high(80, hits);
        chk("R1 high cycles two periods", hits, 20);
        chk("R10 valid while running", longint'(status[3]), 1);

        // R11: a change mid-period keeps the running period intact
        cur_req = "R11";
        tick(250);
        pulse_sync;
        tick(5);
        set_params(40000, 50);
        tick(5);
        count_high(30, hits);
        chk("R11 old period tail stays low", hits, 0);
        chk("R11 next period starts on old boundary", longint'(pwm_out), 1);

        // R4: restart loads new settings (4 kHz, 50 % gives 10 cycles, 5 high)
        cur_req = "R4";
        tick(250);
        pulse_sync;
        count_high(10, hits);
        chk("R4 restart loads new high time", hits, 5);

        // R5: 3 kHz gives 13-cycle period, 6 high; lockout of GAP cycles
        cur_req = "R5";
        set_params(30000, 50);
        tick(250);
        pulse_sync;
        chk("R1 restart at 3 kHz high", longint'(pwm_out), 1);
        tick(6);
        pulse_sync;
        chk("R5 early restart ignored", longint'(pwm_out), 0);
        tick(GAP - 8);
        pulse_sync;
        tick(1);
        chk("R5 restart at window end accepted", longint'(pwm_out), 1);
        tick(100);

        // R6, R7, R8, R9, R10: band table edges with output enabled
        begin
            int fs[15] = '{2500, 2500, 2501, 5000, 10000, 15000, 20000, 20001,
                           40000, 40000, 40001, 0, 1, 30000, 20001};
            int ds[15] = '{5, 4, 95, 90, 81, 30, 39, 50, 50, 51, 50, 50, 95, 100, 50};
            for (int i = 0; i < 15; i++) begin
                bit e_hi, e_lo;
                exp_flags(fs[i], ds[i], e_hi, e_lo);
                cur_req = (fs[i] == 0 || fs[i] > 40000) ? "R7" : (e_hi || e_lo) ? "R8" : "R6";
                set_params(fs[i], ds[i]);
                tick(2);
                chk({cur_req, " high flag"}, longint'(status[4]), longint'(e_hi));
                chk({cur_req, " low flag"}, longint'(status[5]), longint'(e_lo));
                tick(150);
                if (e_hi || e_lo) begin
                    chk("R9 output low when out of range", longint'(pwm_out), 0);
                    chk("R9 valid low when out of range", longint'(status[3]), 0);
                end else begin
                    chk("R10 valid after start", longint'(status[3]), 1);
                end
            end
        end

        // R2: enable low drops the output at once
        cur_req = "R2";
        tick(200);
        pulse_sync;
        run_en = 1'b0;
        #1;
        chk("R2 output low with enable off", longint'(pwm_out), 0);
        tick(2);
        chk("R2 valid low with enable off", longint'(status[3]), 0);
        tick(20);
        run_en = 1'b1;
        tick(150);

        // R3: gate low stops, gate high restarts from period start
        cur_req = "R3";
        gate_in = 1'b0;
        tick(30);
        chk("R3 output low with gate off", longint'(pwm_out), 0);
        gate_in = 1'b1;
        tick(1);
        chk("R3 restart begins high", longint'(pwm_out), 1);
        tick(100);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule